// File: doc/BRIEF.md
# Load data byte formatter

This block turns a raw 64-bit doubleword fetched from memory into the value a load writes to a register. Memory is little-endian: byte lane i of the doubleword holds the byte at address `base + i`. The low three bits of the load address pick the starting lane. The block moves the requested bytes down to the bottom of the result, optionally in reversed byte order, and keeps 1, 2, 4 or 8 of them. It then fills the upper lanes with zeros or with copies of the sign bit.

A load that runs past the end of a doubleword is presented twice. The first presentation carries the lower doubleword and produces no result, because the block only keeps its bytes. The second presentation carries the following doubleword, with the same offset, size and flags, and the second-half flag set. The block combines the two and releases one result.

When the record flag is set, the block also produces a four-bit condition summary of the result. It can judge the full 64 bits or only the low 32 bits.

Top module: `ldfmt_top`

## Requirements
- R1: While reset is held, and on the first cycle after it, `out_valid` is 0 and `out_data` and `out_cr` are all zero.
- R2: An input accepted at a clock edge (`in_valid` = 1) produces `out_valid` = 1 on the next cycle only. The exception is a first half of a split access, which produces nothing. With `in_valid` = 0, `out_valid` is 0 on the next cycle.
- R3: The size code `in_size` selects 1 byte for 0, 2 for 1, 4 for 2 and 8 for 3. Without reversal, result byte k is the memory byte at address offset + k.
- R4: With `in_rev` = 1, result byte k is the memory byte at offset + N - 1 - k, where N is the access size. The reversal stays within the N accessed bytes.
- R5: With `in_sign` = 0, every result byte at position N and above is zero.
- R6: With `in_sign` = 1, every result byte at position N and above equals 0xFF if bit 7 of result byte N-1 is set, and 0x00 otherwise.
- R7: An access with offset + N > 8 is split. The first presentation (`in_second` = 0) gives no output. The second presentation (`in_second` = 1) gives the full result: bytes at addresses below 8 come from the first doubleword and bytes at addresses 8 and above come from the second, where address k+8 is lane k of the second doubleword.
- R8: With `in_rec` = 1, `out_cr` is {negative, positive, zero, summary-overflow} in bits 3 down to 0. Exactly one of bits 3..1 is set, judged on the signed 64-bit result.
- R9: With `in_mode32` = 1, the sign and zero judgement of R8 uses only the low 32 bits of the result.
- R10: With `in_rec` = 0, `out_cr` is all zero on the output cycle.
- R11: With `in_rec` = 1, bit 0 of `out_cr` equals the `in_so` value given with the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input presentation strobe |
| in_data | input | 64 | Doubleword read from memory |
| in_offset | input | 3 | Low three bits of the load address |
| in_size | input | 2 | Size code: 0=1, 1=2, 2=4, 3=8 bytes |
| in_sign | input | 1 | Sign-extend the result |
| in_rev | input | 1 | Reverse byte order within the access |
| in_second | input | 1 | This is the second doubleword of a split access |
| in_rec | input | 1 | Produce a condition summary |
| in_mode32 | input | 1 | Judge the condition on the low 32 bits only |
| in_so | input | 1 | Summary-overflow bit copied into the condition |
| out_valid | output | 1 | Result valid, one cycle after acceptance |
| out_data | output | 64 | Formatted result |
| out_cr | output | 4 | {neg, pos, zero, so}, or zero when not recording |

## Verification
The assertions check, on every cycle, the properties that hold for every load:
- a result never appears without an accepted input on the cycle before;
- the first half of a split access never yields a result;
- a recorded condition always has exactly one of negative, positive and zero set, and a non-recorded one is zero;
- zero- and sign-filled upper bytes are uniform for the narrow sizes.

Only the bench's scenarios can show that the right byte lands in each lane. That covers every offset, size and reversal, the splice boundary of split loads, and the 32-bit condition judgement. The bench shows this by comparing every cycle against a byte-addressed memory model.

// File: rtl/ldfmt_pkg.sv
// Package: shared size codes for the load data formatter.
// Assumes the size code is the base-2 log of the byte count.
package ldfmt_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } size_code_e;
endpackage

// File: rtl/ldfmt_xbar.sv
// Module: per-lane any-to-any byte selector.
// Each output lane picks one input byte. The pick folds the address rotation
// and the optional byte reversal into a single multiplexer level.
// first_mask[j] says whether the byte for lane j lies in the first doubleword,
// that is, whether its address stays below the doubleword boundary.
// Assumes nbytes is a power of two no larger than LANES.
module ldfmt_xbar #(
    parameter int LANES  = 8,
    parameter int LANE_W = 8,
    localparam int DATA_W = LANES * LANE_W,
    localparam int OFF_W  = $clog2(LANES),
    localparam int IDX_W  = OFF_W + 1
) (
    input  logic [DATA_W-1:0] data,
    input  logic [OFF_W-1:0]  off,
    input  logic [IDX_W-1:0]  nbytes,
    input  logic              rev,
    output logic [DATA_W-1:0] sel,
    output logic [LANES-1:0]  first_mask
);
    for (genvar j = 0; j < LANES; j++) begin : g_lane
        logic [IDX_W-1:0] idx;
        logic [IDX_W-1:0] pos;
        logic [OFF_W-1:0] src;

        // Work out which access byte this lane carries, and its address.
        always_comb begin
            idx = rev ? (nbytes - IDX_W'(1) - IDX_W'(j)) : IDX_W'(j);
            pos = {1'b0, off} + idx;
            src = pos[OFF_W-1:0];
        end

        // Pick the byte and flag whether it comes from the lower doubleword.
        always_comb begin
            sel[j*LANE_W +: LANE_W] = data[src*LANE_W +: LANE_W];
            first_mask[j]           = ~pos[OFF_W];
        end
    end
endmodule

// File: rtl/ldfmt_ext.sv
// Module: trim to access size and extend.
// Lanes below nbytes pass through unchanged. The lanes above are filled with
// zeros, or with the top bit of the last kept lane when sign is set.
module ldfmt_ext #(
    parameter int LANES  = 8,
    parameter int LANE_W = 8,
    localparam int DATA_W = LANES * LANE_W,
    localparam int IDX_W  = $clog2(LANES) + 1
) (
    input  logic [DATA_W-1:0] bytes_in,
    input  logic [IDX_W-1:0]  nbytes,
    input  logic              sign,
    output logic [DATA_W-1:0] result
);
    logic msb;

    // Find the sign bit of the highest kept lane.
    always_comb begin
        msb = 1'b0;
        for (int j = 0; j < LANES; j++) begin
            if (IDX_W'(j) == nbytes - IDX_W'(1)) begin
                msb = bytes_in[j*LANE_W + LANE_W - 1];
            end
        end
    end

    // Keep the lanes inside the access size and fill the rest.
    always_comb begin
        for (int j = 0; j < LANES; j++) begin
            if (IDX_W'(j) < nbytes) begin
                result[j*LANE_W +: LANE_W] = bytes_in[j*LANE_W +: LANE_W];
            end else begin
                result[j*LANE_W +: LANE_W] = {LANE_W{sign & msb}};
            end
        end
    end
endmodule

// File: rtl/ldfmt_cond.sv
// Module: condition summary of a result.
// Produces {neg, pos, zero, so} from the full width or from the low half.
// The output is all zero when recording is off.
module ldfmt_cond #(
    parameter int DATA_W = 64,
    localparam int HALF_W = DATA_W / 2
) (
    input  logic [DATA_W-1:0] value,
    input  logic              half_mode,
    input  logic              rec,
    input  logic              so,
    output logic [3:0]        cr
);
    logic neg;
    logic zero;
    logic pos;

    // Judge the sign and zero-ness on the selected width.
    always_comb begin
        neg  = half_mode ? value[HALF_W-1] : value[DATA_W-1];
        zero = half_mode ? (value[HALF_W-1:0] == '0) : (value == '0);
        pos  = ~neg & ~zero;
        cr   = rec ? {neg, pos, zero, so} : 4'b0000;
    end
endmodule

// File: rtl/ldfmt_top.sv
// Module: load data byte formatter, top level.
// Rotates, optionally reverses, splices, trims and extends a loaded doubleword.
// It also produces a condition summary.
// A split access is presented twice with identical control and in_second set
// on the second presentation. The output is registered, with one cycle of
// latency. Assumes the first half of a split access comes before its second.
module ldfmt_top #(
    parameter int LANES  = 8,
    parameter int LANE_W = 8,
    localparam int DATA_W = LANES * LANE_W,
    localparam int OFF_W  = $clog2(LANES),
    localparam int IDX_W  = OFF_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [63:0]       in_data,
    input  logic [2:0]        in_offset,
    input  logic [1:0]        in_size,
    input  logic              in_sign,
    input  logic              in_rev,
    input  logic              in_second,
    input  logic              in_rec,
    input  logic              in_mode32,
    input  logic              in_so,
    output logic              out_valid,
    output logic [63:0]       out_data,
    output logic [3:0]        out_cr
);
    import ldfmt_pkg::*;

    size_code_e        size_code;
    logic [IDX_W-1:0]  nbytes;
    logic [IDX_W:0]    span_end;
    logic              split;
    logic              hold_first;
    logic              emit;
    logic [DATA_W-1:0] sel;
    logic [LANES-1:0]  first_mask;
    logic [DATA_W-1:0] held_q;
    logic [DATA_W-1:0] spliced;
    logic [DATA_W-1:0] formatted;
    logic [3:0]        cr_next;

    // Decode the size and detect an access that crosses the doubleword end.
    always_comb begin
        size_code  = size_code_e'(in_size);
        nbytes     = IDX_W'(1) << size_code;
        span_end   = {2'b00, in_offset} + {1'b0, nbytes};
        split      = span_end > (IDX_W+1)'(LANES);
        hold_first = in_valid & split & ~in_second;
        emit       = in_valid & ~hold_first;
    end

    ldfmt_xbar #(.LANES(LANES), .LANE_W(LANE_W)) u_xbar (
        .data       (in_data),
        .off        (in_offset),
        .nbytes     (nbytes),
        .rev        (in_rev),
        .sel        (sel),
        .first_mask (first_mask)
    );

    // Keep the rotated first doubleword of a split access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= '0;
        end else if (hold_first) begin
            held_q <= sel;
        end
    end

    // Splice held bytes with current bytes on a second-half presentation.
    always_comb begin
        for (int j = 0; j < LANES; j++) begin
            if (in_second && first_mask[j]) begin
                spliced[j*LANE_W +: LANE_W] = held_q[j*LANE_W +: LANE_W];
            end else begin
                spliced[j*LANE_W +: LANE_W] = sel[j*LANE_W +: LANE_W];
            end
        end
    end

    ldfmt_ext #(.LANES(LANES), .LANE_W(LANE_W)) u_ext (
        .bytes_in (spliced),
        .nbytes   (nbytes),
        .sign     (in_sign),
        .result   (formatted)
    );

    ldfmt_cond #(.DATA_W(DATA_W)) u_cond (
        .value     (formatted),
        .half_mode (in_mode32),
        .rec       (in_rec),
        .so        (in_so),
        .cr        (cr_next)
    );

    // Register the result, its condition and the valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_cr    <= '0;
        end else begin
            out_valid <= emit;
            if (emit) begin
                out_data <= formatted;
                out_cr   <= cr_next;
            end
        end
    end

    // A result follows an accepted input by exactly one cycle (R2).
    p_valid_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));

    // The first half of a split access never yields a result (R7).
    p_first_half_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_second && ({2'b00, in_offset} + {1'b0, nbytes} > (IDX_W+1)'(LANES)))
        |=> !out_valid);

    // A recorded condition has exactly one of neg, pos, zero set (R8).
    p_cr_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(in_rec)) |-> ($countones(out_cr[3:1]) == 1));

    // No recording gives an all-zero condition (R10).
    p_cr_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !$past(in_rec)) |-> (out_cr == 4'b0000));

    // Zero extension of a one-byte load clears the upper bytes (R5).
    p_zero_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(!in_sign && in_size == 2'd0)) |-> (out_data[63:8] == '0));

    // Sign extension of a two-byte load copies bit 15 upward (R6).
    p_sign_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(in_sign && in_size == 2'd1))
        |-> (out_data[63:16] == {48{out_data[15]}}));
endmodule

// File: tb/sim_ldfmt_top.sv
// Bench: byte-addressed memory model of loads, compared with the design every cycle.
module sim_ldfmt_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_data = '0;
    logic [2:0]  in_offset = '0;
    logic [1:0]  in_size = '0;
    logic        in_sign = 1'b0;
    logic        in_rev = 1'b0;
    logic        in_second = 1'b0;
    logic        in_rec = 1'b0;
    logic        in_mode32 = 1'b0;
    logic        in_so = 1'b0;
    logic        out_valid;
    logic [63:0] out_data;
    logic [3:0]  out_cr;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [7:0] mem [16];

    always #2.5 clk = ~clk;

    ldfmt_top u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_offset(in_offset), .in_size(in_size), .in_sign(in_sign),
        .in_rev(in_rev), .in_second(in_second), .in_rec(in_rec),
        .in_mode32(in_mode32), .in_so(in_so), .out_valid(out_valid),
        .out_data(out_data), .out_cr(out_cr)
    );

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 50000) begin
                checks++;
                errors++;
                $display("FAIL watchdog: actual %0d cycles, expected under 50000", cycles);
                finish_run();
            end
        end
    end

    function automatic logic [63:0] dword(input int base);
        logic [63:0] d;
        for (int i = 0; i < 8; i++) d[i*8 +: 8] = mem[base + i];
        return d;
    endfunction

    function automatic logic [63:0] model_value(input int addr, input int sz, input bit rev, input bit sgn);
        logic [63:0] v;
        int n;
        bit neg;
        n = 1 << sz;
        v = '0;
        for (int k = 0; k < n; k++) v[k*8 +: 8] = mem[addr + (rev ? (n - 1 - k) : k)];
        neg = v[n*8 - 1];
        for (int k = n; k < 8; k++) v[k*8 +: 8] = (sgn && neg) ? 8'hFF : 8'h00;
        return v;
    endfunction

    function automatic logic [3:0] model_cr(input logic [63:0] v, input bit m32, input bit rc, input bit so);
        longint s;
        if (!rc) return 4'b0000;
        s = m32 ? longint'($signed(v[31:0])) : longint'($signed(v));
        if (s < 0) return {3'b100, so};
        if (s == 0) return {3'b001, so};
        return {3'b010, so};
    endfunction

    // One cycle: drive at the falling edge, check just after the rising edge.
    task automatic step(input bit v, input logic [63:0] d, input int off, input int sz,
                        input bit sg, input bit rv, input bit sec, input bit rc,
                        input bit m32, input bit so, input bit exp_v,
                        input logic [63:0] exp_d, input logic [3:0] exp_cr,
                        input string tag_d, input string tag_c);
        @(negedge clk);
        in_valid = v; in_data = d; in_offset = 3'(off); in_size = 2'(sz);
        in_sign = sg; in_rev = rv; in_second = sec; in_rec = rc;
        in_mode32 = m32; in_so = so;
        @(posedge clk);
        #1;
        checks++;
        if (out_valid !== exp_v) begin
            errors++;
            $display("FAIL R2 valid: actual %b expected %b", out_valid, exp_v);
        end
        if (exp_v) begin
            checks++;
            if (out_data !== exp_d) begin
                errors++;
                $display("FAIL %s data: actual %h expected %h", tag_d, out_data, exp_d);
            end
            checks++;
            if (out_cr !== exp_cr) begin
                errors++;
                $display("FAIL %s cr: actual %b expected %b", tag_c, out_cr, exp_cr);
            end
        end
    endtask

    task automatic idle();
        step(0, '0, 0, 0, 0, 0, 0, 0, 0, 0, 0, '0, '0, "R2", "R2");
    endtask

    task automatic load(input int addr, input int sz, input bit rv, input bit sg,
                        input bit rc, input bit m32, input bit so,
                        input string tag_d, input string tag_c);
        logic [63:0] ev;
        logic [3:0]  ec;
        int n;
        n = 1 << sz;
        ev = model_value(addr, sz, rv, sg);
        ec = model_cr(ev, m32, rc, so);
        if (addr + n > 8) begin
            step(1, dword(0), addr, sz, sg, rv, 0, rc, m32, so, 0, '0, '0, "R7", "R7");
            step(1, dword(8), addr, sz, sg, rv, 1, rc, m32, so, 1, ev, ec, tag_d, tag_c);
        end else begin
            step(1, dword(0), addr, sz, sg, rv, 0, rc, m32, so, 1, ev, ec, tag_d, tag_c);
        end
    endtask

    task automatic fill_random();
        for (int i = 0; i < 16; i++) mem[i] = 8'($urandom);
    endtask

    initial begin
        // R1: outputs stay cleared in reset and right after it.
        for (int i = 0; i < 3; i++) begin
            @(posedge clk);
            #1;
            checks++;
            if (out_valid !== 1'b0 || out_data !== '0 || out_cr !== '0) begin
                errors++;
                $display("FAIL R1 reset: actual %b/%h/%b expected 0/0/0", out_valid, out_data, out_cr);
            end
        end
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        checks++;
        if (out_valid !== 1'b0 || out_data !== '0 || out_cr !== '0) begin
            errors++;
            $display("FAIL R1 after reset: actual %b/%h/%b expected 0/0/0", out_valid, out_data, out_cr);
        end
        idle();

        // R3, R4, R6, R7, R8: every offset, size, reversal and extension.
        for (int rep = 0; rep < 4; rep++) begin
            fill_random();
            for (int a = 0; a < 8; a++) begin
                for (int sz = 0; sz < 4; sz++) begin
                    for (int f = 0; f < 4; f++) begin
                        bit rv;
                        bit sg;
                        string t;
                        rv = f[0];
                        sg = f[1];
                        if (a + (1 << sz) > 8) t = "R7";
                        else if (rv) t = "R4";
                        else if (sg) t = "R6";
                        else t = "R3";
                        load(a, sz, rv, sg, 1, 0, rep[0], t, "R8");
                    end
                end
            end
            idle();
        end

        // R5: a one-byte 0xFF load stays positive and zero-filled.
        mem[3] = 8'hFF;
        load(3, 0, 0, 0, 1, 0, 0, "R5", "R8");
        // R6: the same byte with sign extension becomes all ones and negative.
        load(3, 0, 0, 1, 1, 0, 0, "R6", "R8");

        // R8: an all-zero doubleword gives the zero condition.
        for (int i = 0; i < 16; i++) mem[i] = 8'h00;
        load(0, 3, 0, 0, 1, 0, 0, "R3", "R8");
        // R9: upper half set, lower half zero: 32-bit judgement says zero.
        mem[7] = 8'h80;
        load(0, 3, 0, 0, 1, 1, 0, "R3", "R9");
        load(0, 3, 0, 0, 1, 0, 0, "R3", "R8");
        // R9: bit 31 set gives negative in 32-bit mode and positive otherwise.
        mem[7] = 8'h00; mem[3] = 8'h80;
        load(0, 3, 0, 0, 1, 1, 0, "R3", "R9");
        load(0, 3, 0, 0, 1, 0, 0, "R3", "R8");
        // R11: summary-overflow is copied through.
        load(0, 3, 0, 0, 1, 1, 1, "R3", "R11");
        // R10: no recording gives a cleared condition.
        load(0, 3, 0, 0, 0, 0, 1, "R3", "R10");

        // R7: a split load crossing into the second doubleword, with idle gaps.
        fill_random();
        load(6, 2, 0, 1, 1, 0, 0, "R7", "R8");
        idle();
        load(5, 3, 1, 0, 1, 1, 0, "R7", "R9");
        load(7, 1, 1, 1, 0, 0, 0, "R7", "R10");
        idle();
        idle();
        finish_run();
    end
endmodule